// File: doc/BRIEF.md
# EEPROM Row Write Sequencer

This block is the digital control path for a small serial EEPROM array of 8 rows by 16 byte columns (128 bytes). A host frames a transfer by raising a frame enable. While the frame is open, it clocks in bits one at a time, most significant bit first. The first 7 bits are a byte address. Every group of 8 bits after that is a data byte. The data bytes are collected in a 16-entry row buffer, and a mask records which columns have been loaded.

When the frame closes cleanly, the block runs a timed write cycle on the addressed row. First an erase phase drives the row select and the gate-line enable of every loaded column. After a one-clock quiet gap, a program phase keeps the row selected and drives a bit-line enable only for the data bits that are 1. The lengths of both phases are parameters in clock cycles, and their defaults add up to about 5 ms at 125 MHz. Busy is high for the whole cycle, and the buffer is emptied at the end. Generation of the high voltage and sensing of the cells belong to the analog side and are not part of this block.

Top module: `eeprom_row_writer`

## Requirements
- R1: The 7 address bits arrive MSB first. The upper 3 bits select the row (0..7) and the lower 4 bits select the first column (0..15). Neither value takes effect before all 7 bits have been shifted in.
- R2: Each following 8-bit data byte (MSB first) goes into the current column, and the column then advances by one. After column 15 it wraps to column 0 of the same row.
- R3: A byte that lands on a column already loaded in the same frame replaces the earlier byte.
- R4: No write cycle starts and busy stays low if the frame closes in any of these cases: in the middle of the address, with no complete data byte, or part-way through a data byte. Bytes already collected in that frame are discarded.
- R5: The erase phase starts on the second clock edge after the edge that samples frame enable low. It lasts ERASE_CYCLES clocks. During it, busy=1, row_sel is one-hot on the row, gate_en bit c=1 exactly for the loaded columns c, and bit_en=0.
- R6: The program phase lasts PROG_CYCLES clocks. During it, row_sel is one-hot on the row, gate_en=0, and bit_en[8*c+b] equals bit b of the byte in column c for loaded columns and is 0 elsewhere.
- R7: Between erase and program there is exactly one clock with busy=1 and row_sel, gate_en and bit_en all 0.
- R8: After the program phase, busy and all enables return to 0 together. The next write sees only the columns it loads itself.
- R9: Frame, strobe and data activity while the block is busy has no effect, either on the running cycle or afterwards.
- R10: After synchronous reset, busy, row_sel, gate_en and bit_en are all 0.
- R11: At most one bit of row_sel is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_en | input | 1 | Transfer frame; a rising edge opens a frame, a low level closes it |
| bit_vld | input | 1 | Serial bit strobe, sampled on the clock edge |
| ser_in | input | 1 | Serial data bit |
| busy | output | 1 | Write cycle in progress |
| row_sel | output | 8 | One-hot row line enable |
| gate_en | output | 16 | Per-column gate-line enable (erase phase) |
| bit_en | output | 128 | Per-bit line enable, index 8*column+bit (program phase) |

## Verification
A frame that closes on the edge sampling frame enable low produces erase outputs two edges later. These outputs hold for ERASE_CYCLES clocks, then comes a one-clock gap, then PROG_CYCLES clocks of program outputs, and the idle state follows on the very next clock. The bench counts edges from the close of the frame and samples one time unit after each of these boundary edges. For every cycle, it checks the first and last clock of each phase, the gap and the return to idle. Aborted and ignored frames are checked by watching busy at every clock for a fixed window afterwards. Their effect on the buffer is checked through the masks of the write that follows.

// File: rtl/eeprom_row_pkg.sv
package eeprom_row_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_GAP   = 2'd2,
    PH_PROG  = 2'd3
  } phase_t;
endpackage

// File: rtl/erw_serial_front.sv
module erw_serial_front #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int DW   = 8,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = RW + CW,
  localparam int SW  = (AW > DW) ? AW : DW,
  localparam int ACW = $clog2(AW + 1),
  localparam int BCW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          frame_en,
  input  logic          bit_vld,
  input  logic          ser_in,
  output logic [RW-1:0] row,
  output logic          wr,
  output logic [CW-1:0] wr_col,
  output logic [DW-1:0] wr_byte,
  output logic          start,
  output logic          abort
);
  localparam logic [ACW-1:0] ALAST = ACW'(AW - 1);
  localparam logic [BCW-1:0] BLAST = BCW'(DW - 1);

  logic [SW-2:0]  shreg;
  logic [SW-1:0]  sh_next;
  logic           frame_q, in_frame, addr_done, got_byte;
  logic [ACW-1:0] acnt;
  logic [BCW-1:0] bcnt;
  logic [CW-1:0]  col;

  assign sh_next = {shreg, ser_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; frame_q <= 1'b0; in_frame <= 1'b0; addr_done <= 1'b0;
      got_byte <= 1'b0; acnt <= '0; bcnt <= '0; col <= '0; row <= '0;
      wr <= 1'b0; wr_col <= '0; wr_byte <= '0; start <= 1'b0; abort <= 1'b0;
    end else begin
      wr      <= 1'b0;
      start   <= 1'b0;
      abort   <= 1'b0;
      frame_q <= frame_en;
      if (!in_frame) begin
        if (frame_en && !frame_q && !hold) begin
          in_frame  <= 1'b1;
          addr_done <= 1'b0;
          got_byte  <= 1'b0;
          acnt      <= '0;
          bcnt      <= '0;
        end
      end else if (!frame_en) begin
        in_frame <= 1'b0;
        if (got_byte && bcnt == '0) start <= 1'b1;
        else                        abort <= 1'b1;
      end else if (bit_vld) begin
        shreg <= sh_next[SW-2:0];
        if (!addr_done) begin
          acnt <= acnt + 1'b1;
          if (acnt == ALAST) begin
            addr_done <= 1'b1;
            row       <= sh_next[AW-1:CW];
            col       <= sh_next[CW-1:0];
          end
        end else if (bcnt == BLAST) begin
          bcnt     <= '0;
          wr       <= 1'b1;
          wr_col   <= col;
          wr_byte  <= sh_next[DW-1:0];
          col      <= col + 1'b1;
          got_byte <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  // R9
  busy_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !in_frame) |=> !wr);
  // R4
  start_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(start && abort));
endmodule

// File: rtl/erw_row_buffer.sv
module erw_row_buffer #(
  parameter int COLS = 16,
  parameter int DW   = 8,
  localparam int CW  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr,
  input  logic [CW-1:0]     wr_col,
  input  logic [DW-1:0]     wr_byte,
  output logic [COLS-1:0]   loaded,
  output logic [COLS*DW-1:0] data_flat
);
  logic [DW-1:0] mem [COLS];

  always_ff @(posedge clk) begin
    if (wr) mem[wr_col] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
    end else begin
      if (clear) loaded <= '0;
      if (wr)    loaded[wr_col] <= 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_flat
    assign data_flat[c*DW +: DW] = mem[c];
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !wr) |=> (loaded == '0));
endmodule

// File: rtl/erw_phase_seq.sv
module erw_phase_seq
  import eeprom_row_pkg::*;
#(
  parameter int ERASE_CYCLES = 312500,
  parameter int PROG_CYCLES  = 312500,
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
  localparam int NW   = $clog2(MAXC + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   done
);
  localparam logic [NW-1:0] ELAST = NW'(ERASE_CYCLES - 1);
  localparam logic [NW-1:0] PLAST = NW'(PROG_CYCLES - 1);

  logic [NW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_ERASE;
          cnt   <= '0;
        end
        PH_ERASE: if (cnt == ELAST) begin
          phase <= PH_GAP;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_GAP: phase <= PH_PROG;
        PH_PROG: if (cnt == PLAST) begin
          phase <= PH_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5
  start_to_erase_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase == PH_ERASE));
  // R7
  gap_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP) |=> (phase == PH_PROG));
endmodule

// File: rtl/erw_line_drive.sv
module erw_line_drive
  import eeprom_row_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int DW   = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  phase_t             phase,
  input  logic [RW-1:0]      row,
  input  logic [COLS-1:0]    loaded,
  input  logic [COLS*DW-1:0] data_flat,
  output logic               busy,
  output logic [ROWS-1:0]    row_sel,
  output logic [COLS-1:0]    gate_en,
  output logic [COLS*DW-1:0] bit_en
);
  logic [COLS*DW-1:0] prog_vec;
  logic [ROWS-1:0]    row_oh;

  assign row_oh = ROWS'(1) << row;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign prog_vec[c*DW +: DW] = data_flat[c*DW +: DW] & {DW{loaded[c]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; row_sel <= '0; gate_en <= '0; bit_en <= '0;
    end else begin
      busy <= (phase != PH_IDLE);
      unique case (phase)
        PH_ERASE: begin row_sel <= row_oh; gate_en <= loaded; bit_en <= '0;       end
        PH_PROG:  begin row_sel <= row_oh; gate_en <= '0;     bit_en <= prog_vec; end
        default:  begin row_sel <= '0;     gate_en <= '0;     bit_en <= '0;       end
      endcase
    end
  end

  // R11
  onehot_row_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(row_sel));
  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((gate_en != '0) && (bit_en != '0)));
  // R7
  gate_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_en != '0) |=> (bit_en == '0));
  // R8
  end_all_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ((row_sel == '0) && (bit_en == '0)));
endmodule

// File: rtl/eeprom_row_writer.sv
module eeprom_row_writer
  import eeprom_row_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int COLS         = 16,
  parameter int DW           = 8,
  parameter int ERASE_CYCLES = 312500,
  parameter int PROG_CYCLES  = 312500,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_en,
  input  logic               bit_vld,
  input  logic               ser_in,
  output logic               busy,
  output logic [ROWS-1:0]    row_sel,
  output logic [COLS-1:0]    gate_en,
  output logic [COLS*DW-1:0] bit_en
);
  phase_t             phase;
  logic               hold, wr, start, abort, done;
  logic [RW-1:0]      row;
  logic [CW-1:0]      wr_col;
  logic [DW-1:0]      wr_byte;
  logic [COLS-1:0]    loaded;
  logic [COLS*DW-1:0] data_flat;

  assign hold = (phase != PH_IDLE) || start;

  erw_serial_front #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_front (
    .clk(clk), .rst(rst), .hold(hold), .frame_en(frame_en), .bit_vld(bit_vld),
    .ser_in(ser_in), .row(row), .wr(wr), .wr_col(wr_col), .wr_byte(wr_byte),
    .start(start), .abort(abort));

  erw_row_buffer #(.COLS(COLS), .DW(DW)) u_buf (
    .clk(clk), .rst(rst), .clear(done | abort), .wr(wr), .wr_col(wr_col),
    .wr_byte(wr_byte), .loaded(loaded), .data_flat(data_flat));

  erw_phase_seq #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .done(done));

  erw_line_drive #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_drive (
    .clk(clk), .rst(rst), .phase(phase), .row(row), .loaded(loaded),
    .data_flat(data_flat), .busy(busy), .row_sel(row_sel), .gate_en(gate_en),
    .bit_en(bit_en));
endmodule

// File: tb/eeprom_row_writer_test.sv
module eeprom_row_writer_test;
  localparam int E = 40;
  localparam int P = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_en = 1'b0, bit_vld = 1'b0, ser_in = 1'b0;
  logic         busy;
  logic [7:0]   row_sel;
  logic [15:0]  gate_en;
  logic [127:0] bit_en;

  int total = 0, fails = 0;
  logic [7:0]  exp_data [16];
  logic [15:0] exp_mask = '0;
  logic [2:0]  exp_row = '0;

  always #4 clk = ~clk;

  eeprom_row_writer #(.ERASE_CYCLES(E), .PROG_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .frame_en(frame_en), .bit_vld(bit_vld), .ser_in(ser_in),
    .busy(busy), .row_sel(row_sel), .gate_en(gate_en), .bit_en(bit_en));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] prog_bits();
    logic [127:0] v = '0;
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 8; b++) v[c*8+b] = exp_mask[c] & exp_data[c][b];
    return v;
  endfunction

  task automatic drive_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_in = v[i]; bit_vld = 1'b1;
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  task automatic begin_frame();
    frame_en = 1'b1; bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_frame();
    frame_en = 1'b0; bit_vld = 1'b0;
  endtask

  // R1 R2 R3: model update alongside the serial stream
  task automatic load_frame(input logic [2:0] r, input logic [3:0] c, input int n);
    logic [3:0] col = c;
    begin_frame();
    drive_bits({1'b0, r, c}, 7);
    exp_row = r;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      drive_bits(d, 8);
      exp_data[col] = d;
      exp_mask[col] = 1'b1;
      col = col + 1'b1;
    end
    end_frame();
  endtask

  // follows end_frame at a negedge; edge k is the next posedge
  task automatic check_cycle(input string greq);
    logic [7:0] roh = 8'b1 << exp_row;
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b1, "R5", "busy at erase start", 128'(busy), 128'd1);
    chk(row_sel === roh, "R1", "row at erase start", 128'(row_sel), 128'(roh));
    chk(gate_en === exp_mask, greq, "gate mask at erase start", 128'(gate_en), 128'(exp_mask));
    chk(bit_en === '0, "R5", "bit lines in erase", bit_en, 128'd0);
    repeat (E - 1) @(posedge clk);
    #1;
    chk(gate_en === exp_mask && bit_en === '0, "R5", "last erase clock",
        128'(gate_en), 128'(exp_mask));
    @(posedge clk); #1;
    chk(busy === 1'b1 && row_sel === '0 && gate_en === '0 && bit_en === '0, "R7",
        "gap clock", 128'({busy, row_sel, gate_en}), 128'({1'b1, 24'd0}));
    @(posedge clk); #1;
    chk(row_sel === roh && gate_en === '0, "R6", "program row/gate",
        128'({row_sel, gate_en}), 128'({roh, 16'd0}));
    chk(bit_en === prog_bits(), "R6", "program bit lines", bit_en, prog_bits());
    repeat (P - 1) @(posedge clk);
    #1;
    chk(bit_en === prog_bits() && busy === 1'b1, "R6", "last program clock",
        bit_en, prog_bits());
    @(posedge clk); #1;
    chk(busy === 1'b0 && row_sel === '0 && gate_en === '0 && bit_en === '0, "R8",
        "idle after cycle", 128'({busy, row_sel, gate_en, bit_en[7:0]}), 128'd0);
    exp_mask = '0;
    @(negedge clk);
  endtask

  // R4: frame closed early; busy must never rise
  task automatic aborted(input int abits, input int nbytes, input int extra);
    bit seen = 1'b0;
    begin_frame();
    drive_bits(8'($urandom), abits);
    for (int i = 0; i < nbytes; i++) drive_bits(8'($urandom), 8);
    if (extra > 0) drive_bits(8'($urandom), extra);
    end_frame();
    repeat (10) begin
      @(negedge clk);
      if (busy !== 1'b0) seen = 1'b1;
    end
    chk(!seen, "R4", $sformatf("abort a%0d b%0d x%0d", abits, nbytes, extra),
        128'(seen), 128'd0);
    exp_mask = '0;
  endtask

  task automatic intruder();
    repeat (3) @(negedge clk);
    begin_frame();
    drive_bits(8'h7F, 7);
    drive_bits(8'hFF, 8);
    drive_bits(8'hFF, 8);
    end_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int c = 0; c < 16; c++) exp_data[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(busy === 0 && row_sel === 0 && gate_en === 0 && bit_en === 0, "R10",
        "reset state", 128'({busy, row_sel, gate_en}), 128'd0);

    // R2: wrap from column 15 to 0 in row 7
    load_frame(3'd7, 4'd14, 4);
    check_cycle("R2");
    // R3: 18 bytes from column 0 overwrite columns 0 and 1
    load_frame(3'd2, 4'd0, 18);
    check_cycle("R3");
    // R8: single byte right after a full row shows one column only
    load_frame(3'd0, 4'd9, 1);
    check_cycle("R8");

    aborted(4, 0, 0);
    aborted(7, 0, 0);
    aborted(7, 0, 5);
    aborted(7, 2, 3);
    // R4: bytes from the aborted frame are gone
    load_frame(3'd5, 4'd3, 1);
    check_cycle("R4");

    // R9: a frame during the busy cycle is ignored
    load_frame(3'd4, 4'd6, 2);
    fork
      check_cycle("R9");
      intruder();
    join
    begin
      bit seen = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (busy !== 1'b0) seen = 1'b1;
      end
      chk(!seen, "R9", "no cycle from ignored frame", 128'(seen), 128'd0);
    end

    // random writes
    for (int t = 0; t < 10; t++) begin
      load_frame(3'($urandom), 4'($urandom), 1 + int'($urandom % 20));
      check_cycle("R5");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule